// File: doc/BRIEF.md
# USB Host Controller Register File

This block is the software-visible register set of a USB 1.1 style host controller. A CPU reaches it over a simple I/O bus with 5-bit addresses and three access widths: byte, word (16 bits) and longword (32 bits). It holds the command word, the status word with two hidden interrupt-cause flags, the interrupt enable mask, the 11-bit frame counter, the frame list base pointer, the start-of-frame timing byte, and one control/status word for each root port.

The schedule engine, which is not part of this block, reports its outcomes on single-cycle event inputs: completion, short packet, transaction error, host system error and process error. It also advances the frame counter with `frame_tick`. Device connect and disconnect arrive on per-port strobes. The block returns a level interrupt, the run flag, the current frame number, and a one-cycle bus-reset request for each port.

Read data is combinational from `addr` and `size`, so there is no read strobe. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `usbhc_regs`

## Requirements
- R1: After `rst_n` the command, status, interrupt-enable, frame number and base registers read 0, the timing byte at 0x0c reads 64, each port word reads 0x0080, and `irq` is low.
- R2: A command write (word, 0x00) whose bit 0 goes from 0 to 1 clears halted status bit 5. A command write with bit 0 clear sets bit 5. A `frame_tick` while bit 0 of the command is clear also sets bit 5.
- R3: A command write with bit 1 (controller reset) or bit 2 (global reset) set does not store the value. It restores the R1 values of command, status, cause flags, enable, base, timing byte and port words, and it keeps the frame number. A port that is connected at that time is reported again as connected with connect change set and its speed bit kept. Global reset also raises `port_bus_reset` for one cycle on each connected port.
- R4: A status write (word, 0x02) clears each status bit written as 1. Writing bit 0 also clears both hidden cause flags (completion and short packet).
- R5: The frame number (word, 0x06) is 11 bits wide and takes writes only while status bit 5 is set. `frame_tick` while running increments it modulo 2048.
- R6: The base register (longword, 0x08) stores bits 31:12 of the written value, and bits 11:0 always read 0.
- R7: `irq` is high when any of the following holds: completion flag with enable bit 2; short-packet flag with enable bit 3; status bit 1 with enable bit 0; status bit 2 with enable bit 1; status bit 3 or bit 4 on its own.
- R8: A port word write (0x10 for port 0, 0x12 for port 1) keeps the bits in mask 0x01fb and takes the other bits from the data. It then clears bit 1 (connect change) and bit 3 (enable change) where the data has a 1.
- R9: A port write that takes bit 9 from 0 to 1 on a connected port (bit 0 set) raises that port's `port_bus_reset` for exactly one cycle. The output rises in the cycle after the write edge.
- R10: An attach strobe sets port bits 0 and 1 and copies `attach_low_speed` to bit 8. A detach strobe clears bit 0 and sets bit 1 if bit 0 was set. If bit 2 (enabled) was set, detach clears it and sets bit 3.
- R11: An attach or detach while command bit 3 (global suspend) is set also sets command bit 4 (forced resume) and status bit 2. With bit 3 clear, the command and status words do not change.
- R12: `size` encodes 0 as byte, 1 as word, and 2 or 3 as longword. Reads of unmapped locations return 0xff for byte width, 0xff7f for word width (this includes port slots at or beyond NPORTS) and 0xffffffff for longword width.
- R13: `done_evt` sets the completion flag and status bit 0. `short_evt` sets the short-packet flag and status bit 0. `err_evt`, `hse_evt` and `prc_evt` set status bits 1, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current access |
| size | input | 2 | Access width: 0 byte, 1 word, 2/3 longword |
| addr | input | 5 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| done_evt | input | 1 | Transfer completion with interrupt request |
| short_evt | input | 1 | Short packet detected |
| err_evt | input | 1 | Transaction error |
| hse_evt | input | 1 | Host system error |
| prc_evt | input | 1 | Schedule process error |
| attach_evt | input | NPORTS | Per-port device connect strobe |
| detach_evt | input | NPORTS | Per-port device disconnect strobe |
| attach_low_speed | input | NPORTS | Speed of the device being attached (1 = low) |
| irq | output | 1 | Level interrupt |
| running | output | 1 | Command run bit |
| frame_num | output | 11 | Current frame number |
| port_bus_reset | output | NPORTS | One-cycle bus-reset request per port |

## Verification
A wrong hidden cause flag cannot be read back directly. It shows on `irq` in the cycle after the event or the status write, so the bench sweeps every enable mask against every cause and compares the level immediately. A corrupted halted bit shows at the next frame write or tick as a frame number that changes or stays when it should not. A stale port connect bit shows one cycle after a reset write, as a bus-reset pulse on the wrong port.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;

  // command bit positions (software decodes these)
  localparam int unsigned CMD_RUN  = 0;
  localparam int unsigned CMD_HCR  = 1;
  localparam int unsigned CMD_GRS  = 2;
  localparam int unsigned CMD_SUSP = 3;
  localparam int unsigned CMD_FRES = 4;

  // status bit positions
  localparam int unsigned ST_INT = 0;
  localparam int unsigned ST_ERR = 1;
  localparam int unsigned ST_RES = 2;
  localparam int unsigned ST_HSE = 3;
  localparam int unsigned ST_PRC = 4;
  localparam int unsigned ST_HLT = 5;
  localparam int unsigned ST_W   = 6;

  localparam logic [4:0] A_CMD  = 5'h00;
  localparam logic [4:0] A_STS  = 5'h02;
  localparam logic [4:0] A_IEN  = 5'h04;
  localparam logic [4:0] A_FRN  = 5'h06;
  localparam logic [4:0] A_BASE = 5'h08;
  localparam logic [4:0] A_SOFT = 5'h0c;

  localparam int unsigned FRN_W = 11;
  localparam logic [7:0]  SOF_RST = 8'd64;

  localparam logic [15:0] PORT_KEEP = 16'h01fb;
  localparam logic [15:0] PORT_W1C  = 16'h000a;
  localparam logic [15:0] PORT_RST  = 16'h0080;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LNG2 = 2'd3
  } acc_size_e;

  // merged port word after a software write
  function automatic logic [15:0] port_write(input logic [15:0] cur,
                                             input logic [15:0] val);
    logic [15:0] merged;
    merged = (cur & PORT_KEEP) | (val & ~PORT_KEEP);
    return merged & ~(val & PORT_W1C);
  endfunction

  // interrupt level from status, hidden causes and enables
  function automatic logic irq_level(input logic [ST_W-1:0] sts,
                                     input logic [1:0] cause,
                                     input logic [3:0] en);
    return (cause[0] & en[2]) | (cause[1] & en[3]) |
           (sts[ST_ERR] & en[0]) | (sts[ST_RES] & en[1]) |
           sts[ST_HSE] | sts[ST_PRC];
  endfunction

endpackage

// File: rtl/usbhc_port.sv
module usbhc_port
  import usbhc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        grst,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        attach,
  input  logic        detach,
  input  logic        low_speed,
  output logic [15:0] ctrl,
  output logic        bus_rst,
  output logic        conn_evt
);

  logic [15:0] ctrl_n;
  logic        rst_req;

  always_comb begin
    ctrl_n = ctrl;
    if (soft_rst) begin
      ctrl_n = PORT_RST;
      if (ctrl[0]) ctrl_n = ctrl_n | 16'h0003 | {7'b0, ctrl[8], 8'b0};
    end else if (wr) begin
      ctrl_n = port_write(ctrl, wdata);
    end
    if (attach) begin
      ctrl_n[0] = 1'b1;
      ctrl_n[1] = 1'b1;
      ctrl_n[8] = low_speed;
    end else if (detach) begin
      if (ctrl_n[0]) begin
        ctrl_n[0] = 1'b0;
        ctrl_n[1] = 1'b1;
      end
      if (ctrl_n[2]) begin
        ctrl_n[2] = 1'b0;
        ctrl_n[3] = 1'b1;
      end
    end
  end

  assign rst_req  = ctrl[0] & ((soft_rst & grst) |
                               (!soft_rst & wr & wdata[9] & !ctrl[9]));
  assign conn_evt = attach | detach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= PORT_RST;
      bus_rst <= 1'b0;
    end else begin
      ctrl    <= ctrl_n;
      bus_rst <= rst_req;
    end
  end

endmodule

// File: rtl/usbhc_irq.sv
module usbhc_irq
  import usbhc_pkg::*;
(
  input  logic [ST_W-1:0] sts,
  input  logic [1:0]      cause,
  input  logic [3:0]      en,
  output logic            irq
);
  assign irq = irq_level(sts, cause, en);
endmodule

// File: rtl/usbhc_regs.sv
module usbhc_regs
  import usbhc_pkg::*;
#(
  parameter int unsigned NPORTS = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        size,
  input  logic [4:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              frame_tick,
  input  logic              done_evt,
  input  logic              short_evt,
  input  logic              err_evt,
  input  logic              hse_evt,
  input  logic              prc_evt,
  input  logic [NPORTS-1:0] attach_evt,
  input  logic [NPORTS-1:0] detach_evt,
  input  logic [NPORTS-1:0] attach_low_speed,
  output logic              irq,
  output logic              running,
  output logic [10:0]       frame_num,
  output logic [NPORTS-1:0] port_bus_reset
);

  localparam int unsigned BASE_W = 20;

  logic [15:0]       cmd_q, cmd_n, ien_q, ien_n;
  logic [ST_W-1:0]   sts_q, sts_n;
  logic [1:0]        cause_q, cause_n;
  logic [FRN_W-1:0]  frn_q, frn_n;
  logic [BASE_W-1:0] base_q, base_n;
  logic [7:0]        sof_q, sof_n;

  logic wr_b, wr_w, wr_l;
  logic cmd_wr, sts_wr, ien_wr, frn_wr, base_wr, sof_wr;
  logic soft_rst, grst, resume_fire;

  logic [15:0]       port_ctrl [NPORTS];
  logic [NPORTS-1:0] port_wr, conn_evt, port_conn;

  // access decode
  assign wr_b    = wr_en && (size == SZ_BYTE);
  assign wr_w    = wr_en && (size == SZ_WORD);
  assign wr_l    = wr_en && (size[1] == 1'b1);
  assign cmd_wr  = wr_w && (addr == A_CMD);
  assign sts_wr  = wr_w && (addr == A_STS);
  assign ien_wr  = wr_w && (addr == A_IEN);
  assign frn_wr  = wr_w && (addr == A_FRN);
  assign base_wr = wr_l && (addr == A_BASE);
  assign sof_wr  = wr_b && (addr == A_SOFT);

  assign soft_rst    = cmd_wr && (wdata[CMD_HCR] || wdata[CMD_GRS]);
  assign grst        = cmd_wr && wdata[CMD_GRS];
  assign resume_fire = (|conn_evt) && cmd_q[CMD_SUSP] && !soft_rst;

  // root ports
  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign port_wr[i] = wr_w && addr[4] && (addr[3:1] == 3'(i));
    usbhc_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .grst     (grst),
      .wr       (port_wr[i]),
      .wdata    (wdata[15:0]),
      .attach   (attach_evt[i]),
      .detach   (detach_evt[i]),
      .low_speed(attach_low_speed[i]),
      .ctrl     (port_ctrl[i]),
      .bus_rst  (port_bus_reset[i]),
      .conn_evt (conn_evt[i])
    );
    assign port_conn[i] = port_ctrl[i][0];
  end

  // next-state of the controller-wide registers
  always_comb begin
    cmd_n = cmd_q;  sts_n = sts_q;  cause_n = cause_q; ien_n = ien_q;
    frn_n = frn_q;  base_n = base_q; sof_n = sof_q;
    if (frame_tick) begin
      if (cmd_q[CMD_RUN]) frn_n = frn_q + 11'd1;
      else                sts_n[ST_HLT] = 1'b1;
    end
    if (cmd_wr) begin
      if (wdata[CMD_RUN] && !cmd_q[CMD_RUN]) sts_n[ST_HLT] = 1'b0;
      else if (!wdata[CMD_RUN])              sts_n[ST_HLT] = 1'b1;
      cmd_n = wdata[15:0];
    end
    if (sts_wr) begin
      sts_n = sts_n & ~wdata[ST_W-1:0];
      if (wdata[ST_INT]) cause_n = 2'b00;
    end
    if (ien_wr)                   ien_n  = wdata[15:0];
    if (frn_wr && sts_q[ST_HLT])  frn_n  = wdata[FRN_W-1:0];
    if (base_wr)                  base_n = wdata[31:12];
    if (sof_wr)                   sof_n  = wdata[7:0];
    if (soft_rst) begin
      cmd_n = '0; sts_n = '0; cause_n = '0; ien_n = '0;
      base_n = '0; sof_n = SOF_RST;
    end
    if (done_evt)  begin cause_n[0] = 1'b1; sts_n[ST_INT] = 1'b1; end
    if (short_evt) begin cause_n[1] = 1'b1; sts_n[ST_INT] = 1'b1; end
    if (err_evt) sts_n[ST_ERR] = 1'b1;
    if (hse_evt) sts_n[ST_HSE] = 1'b1;
    if (prc_evt) sts_n[ST_PRC] = 1'b1;
    if (resume_fire) begin
      cmd_n[CMD_FRES] = 1'b1;
      sts_n[ST_RES]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; sts_q <= '0; cause_q <= '0; ien_q <= '0;
      frn_q <= '0; base_q <= '0; sof_q <= SOF_RST;
    end else begin
      cmd_q <= cmd_n; sts_q <= sts_n; cause_q <= cause_n; ien_q <= ien_n;
      frn_q <= frn_n; base_q <= base_n; sof_q <= sof_n;
    end
  end

  // read path
  always_comb begin
    unique case (size)
      SZ_BYTE: rdata = (addr == A_SOFT) ? {24'b0, sof_q} : 32'h0000_00ff;
      SZ_WORD: begin
        rdata = 32'h0000_ff7f;
        unique case (addr)
          A_CMD: rdata = {16'b0, cmd_q};
          A_STS: rdata = {26'b0, sts_q};
          A_IEN: rdata = {16'b0, ien_q};
          A_FRN: rdata = {21'b0, frn_q};
          default: begin
            for (int i = 0; i < NPORTS; i++)
              if (addr[4] && (addr[3:1] == 3'(i))) rdata = {16'b0, port_ctrl[i]};
          end
        endcase
      end
      default: rdata = (addr == A_BASE) ? {base_q, 12'b0} : 32'hffff_ffff;
    endcase
  end

  usbhc_irq u_irq (
    .sts  (sts_q),
    .cause(cause_q),
    .en   (ien_q[3:0]),
    .irq  (irq)
  );

  assign running   = cmd_q[CMD_RUN];
  assign frame_num = frn_q;

endmodule

// File: rtl/usbhc_regs_chk.sv
module usbhc_regs_chk #(
  parameter int unsigned NPORTS = 2
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        size,
  input logic [4:0]        addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              frame_tick,
  input logic              done_evt,
  input logic              short_evt,
  input logic              irq,
  input logic              running,
  input logic [10:0]       frame_num,
  input logic [5:0]        sts_q,
  input logic [1:0]        cause_q,
  input logic [NPORTS-1:0] port_conn,
  input logic [NPORTS-1:0] port_bus_reset
);

  logic word_wr, cmd_plain;
  assign word_wr   = wr_en && (size == 2'd1);
  assign cmd_plain = word_wr && (addr == 5'h00) && !wdata[1] && !wdata[2];

  // fatal status bits raise the interrupt regardless of enables
  p_fatal_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[3] || sts_q[4]) |-> irq);

  // frame number is locked while the controller runs
  p_frame_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && addr == 5'h06 && !sts_q[5] && !frame_tick) |=> $stable(frame_num));

  // clearing the interrupt bit clears the hidden causes
  p_cause_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && addr == 5'h02 && wdata[0] && !done_evt && !short_evt) |=> (cause_q == 2'b00));

  // starting the controller leaves the halted state
  p_run_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_plain && wdata[0] && !running) |=> !sts_q[5]);

  // a bus reset goes only to a port that was connected
  p_reset_conn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_bus_reset) |-> ((port_bus_reset & ~$past(port_conn)) == '0));

  // base register low bits read as zero
  p_base_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (size[1] && addr == 5'h08) |-> (rdata[11:0] == 12'h000));

endmodule

bind usbhc_regs usbhc_regs_chk #(.NPORTS(NPORTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .size          (size),
  .addr          (addr),
  .wdata         (wdata),
  .rdata         (rdata),
  .frame_tick    (frame_tick),
  .done_evt      (done_evt),
  .short_evt     (short_evt),
  .irq           (irq),
  .running       (running),
  .frame_num     (frame_num),
  .sts_q         (sts_q),
  .cause_q       (cause_q),
  .port_conn     (port_conn),
  .port_bus_reset(port_bus_reset)
);

// File: tb/usbhc_regs_tb.sv
module usbhc_regs_tb_top;

  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    size = 2'd1;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          frame_tick = 1'b0;
  logic          done_evt = 1'b0, short_evt = 1'b0, err_evt = 1'b0;
  logic          hse_evt = 1'b0, prc_evt = 1'b0;
  logic [NP-1:0] attach_evt = '0, detach_evt = '0, attach_low_speed = '0;
  logic          irq, running;
  logic [10:0]   frame_num;
  logic [NP-1:0] port_bus_reset;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  usbhc_regs #(.NPORTS(NP)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; size = sz; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    size = sz; addr = a;
    #1 d = rdata;
  endtask

  // one-cycle cause: 0 done, 1 short, 2 err, 3 resume, 4 hse, 5 prc
  task automatic fire(input int c);
    if (c == 3) begin
      wr(2'd1, 5'h00, 32'h8);
      @(negedge clk); attach_evt[0] = 1'b1; attach_low_speed[0] = 1'b0;
      @(negedge clk); attach_evt[0] = 1'b0;
    end else begin
      @(negedge clk);
      case (c)
        0: done_evt = 1'b1;
        1: short_evt = 1'b1;
        2: err_evt = 1'b1;
        4: hse_evt = 1'b1;
        default: prc_evt = 1'b1;
      endcase
      @(negedge clk);
      {done_evt, short_evt, err_evt, hse_evt, prc_evt} = '0;
    end
  endtask

  task automatic port_ev(input int p, input bit att, input bit ls);
    @(negedge clk);
    if (att) begin attach_evt[p] = 1'b1; attach_low_speed[p] = ls; end
    else detach_evt[p] = 1'b1;
    @(negedge clk);
    attach_evt = '0; detach_evt = '0;
  endtask

  task automatic tick;
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic        e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, 5'h00, v); chk("R1 cmd", v, 32'h0);
    rd(2'd1, 5'h02, v); chk("R1 status", v, 32'h0);
    rd(2'd1, 5'h04, v); chk("R1 enable", v, 32'h0);
    rd(2'd1, 5'h06, v); chk("R1 frame", v, 32'h0);
    rd(2'd2, 5'h08, v); chk("R1 base", v, 32'h0);
    rd(2'd0, 5'h0c, v); chk("R1 sof", v, 32'd64);
    rd(2'd1, 5'h10, v); chk("R1 port0", v, 32'h0080);
    rd(2'd1, 5'h12, v); chk("R1 port1", v, 32'h0080);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R12 unmapped reads
    rd(2'd1, 5'h0a, v); chk("R12 word hole", v, 32'hff7f);
    rd(2'd1, 5'h14, v); chk("R12 port2", v, 32'hff7f);
    rd(2'd2, 5'h00, v); chk("R12 long hole", v, 32'hffffffff);
    rd(2'd0, 5'h00, v); chk("R12 byte hole", v, 32'hff);

    // R6 base and timing byte
    wr(2'd2, 5'h08, 32'hdeadbeef);
    rd(2'd2, 5'h08, v); chk("R6 base", v, 32'hdeadb000);
    wr(2'd0, 5'h0c, 32'h3c);
    rd(2'd0, 5'h0c, v); chk("R1 sof write", v, 32'h3c);

    // R5 frame lock while not halted, R2 run/halt
    wr(2'd1, 5'h06, 32'h1234);
    rd(2'd1, 5'h06, v); chk("R5 frame locked", v, 32'h0);
    wr(2'd1, 5'h00, 32'h0);
    rd(2'd1, 5'h02, v); chk("R2 halt set", v, 32'h20);
    wr(2'd1, 5'h06, 32'hffff);
    rd(2'd1, 5'h06, v); chk("R5 frame 11 bits", v, 32'h7ff);
    wr(2'd1, 5'h00, 32'h1);
    rd(2'd1, 5'h02, v); chk("R2 halt clear", v, 32'h0);
    tick();
    chk("R5 wrap", {21'b0, frame_num}, 32'h0);
    tick();
    chk("R5 inc", {21'b0, frame_num}, 32'h1);
    wr(2'd1, 5'h06, 32'h5);
    chk("R5 run lock", {21'b0, frame_num}, 32'h1);
    wr(2'd1, 5'h01 ^ 5'h01, 32'h0);
    tick();
    chk("R2 tick halted", {21'b0, frame_num}, 32'h1);
    rd(2'd1, 5'h02, v); chk("R2 halted status", v, 32'h20);

    // R3 soft reset restores values, keeps frame
    wr(2'd1, 5'h00, 32'h2);
    rd(2'd1, 5'h00, v); chk("R3 cmd not stored", v, 32'h0);
    rd(2'd2, 5'h08, v); chk("R3 base", v, 32'h0);
    rd(2'd0, 5'h0c, v); chk("R3 sof", v, 32'd64);
    rd(2'd1, 5'h06, v); chk("R3 frame kept", v, 32'h1);

    // R7 / R13 interrupt sweep
    for (int c = 0; c < 6; c++) begin
      for (int en = 0; en < 16; en++) begin
        wr(2'd1, 5'h00, 32'h2);
        wr(2'd1, 5'h04, en);
        fire(c);
        case (c)
          0: e = en[2];
          1: e = en[3];
          2: e = en[0];
          3: e = en[1];
          default: e = 1'b1;
        endcase
        chk($sformatf("R7 cause%0d en%0d", c, en), {31'b0, irq}, {31'b0, e});
      end
    end

    // R13 status bits from events, R4 write-one-to-clear
    wr(2'd1, 5'h00, 32'h2);
    fire(2); fire(4);
    rd(2'd1, 5'h02, v); chk("R13 err+hse", v, 32'h0a);
    wr(2'd1, 5'h02, 32'h02);
    rd(2'd1, 5'h02, v); chk("R4 clear err", v, 32'h08);
    chk("R7 hse irq", {31'b0, irq}, 32'h1);
    wr(2'd1, 5'h02, 32'h08);
    chk("R4 hse cleared irq", {31'b0, irq}, 32'h0);
    wr(2'd1, 5'h04, 32'h4);
    fire(0);
    rd(2'd1, 5'h02, v); chk("R13 done status", v, 32'h01);
    wr(2'd1, 5'h02, 32'h02);
    chk("R4 flag kept", {31'b0, irq}, 32'h1);
    wr(2'd1, 5'h02, 32'h01);
    rd(2'd1, 5'h02, v); chk("R4 int cleared", v, 32'h0);
    chk("R4 flags cleared", {31'b0, irq}, 32'h0);

    // R10 / R8 / R9 on port 1 (port 0 connected full speed from sweep)
    rd(2'd1, 5'h10, v); chk("R3 port0 reattached", v, 32'h0083);
    port_ev(1, 1'b1, 1'b1);
    rd(2'd1, 5'h12, v); chk("R10 attach low", v, 32'h0183);
    rd(2'd1, 5'h00, v); chk("R11 no suspend", v, 32'h0);
    wr(2'd1, 5'h12, 32'h000a);
    rd(2'd1, 5'h12, v); chk("R8 w1c", v, 32'h0181);
    wr(2'd1, 5'h12, 32'h0004);
    rd(2'd1, 5'h12, v); chk("R8 enable", v, 32'h0185);
    port_ev(1, 1'b0, 1'b0);
    rd(2'd1, 5'h12, v); chk("R10 detach", v, 32'h018a);
    port_ev(1, 1'b1, 1'b0);
    rd(2'd1, 5'h12, v); chk("R10 attach full", v, 32'h008b);
    wr(2'd1, 5'h12, 32'h0200);
    chk("R9 pulse", {30'b0, port_bus_reset}, 32'h2);
    @(negedge clk);
    chk("R9 one cycle", {30'b0, port_bus_reset}, 32'h0);
    rd(2'd1, 5'h12, v); chk("R8 reset bit", v, 32'h028b);
    wr(2'd1, 5'h12, 32'h0200);
    chk("R9 no repeat", {30'b0, port_bus_reset}, 32'h0);

    // R11 resume under suspend
    wr(2'd1, 5'h00, 32'h8);
    port_ev(1, 1'b0, 1'b0);
    rd(2'd1, 5'h00, v); chk("R11 cmd resume", v, 32'h18);
    rd(2'd1, 5'h02, v); chk("R11 status resume", v, 32'h24);
    rd(2'd1, 5'h12, v); chk("R10 detach no enable", v, 32'h028a);

    // R3 global reset pulses connected ports only
    wr(2'd1, 5'h00, 32'h4);
    chk("R3 global pulse", {30'b0, port_bus_reset}, 32'h1);
    rd(2'd1, 5'h10, v); chk("R3 port0 after", v, 32'h0083);
    rd(2'd1, 5'h12, v); chk("R3 port1 after", v, 32'h0080);
    rd(2'd1, 5'h06, v); chk("R3 frame kept global", v, 32'h1);
    port_ev(0, 1'b0, 1'b0);
    rd(2'd1, 5'h10, v); chk("R10 detach port0", v, 32'h0082);
    wr(2'd1, 5'h00, 32'h2);
    chk("R3 hc reset no pulse", {30'b0, port_bus_reset}, 32'h0);
    rd(2'd1, 5'h10, v); chk("R3 port0 idle", v, 32'h0080);

    finish_run();
  end

endmodule